// File: doc/BRIEF.md
# Self-Programming Flash Sequencer

This block sits next to a CPU core and turns flash self-programming requests into a short, guarded handshake with the flash array. Software writes an 8-bit control register with a command pattern and an enable bit set. That write opens a brief window. Within it, a store-program strobe from the core launches the chosen operation: page erase, page write, page-buffer load, re-enabling reads of the section that was being programmed, or a lock-byte update. If no strobe comes before the window closes, the command is dropped.

The flash array is reached through a start pulse with a 2-bit command and a done input. The enable bit stays set for as long as the operation runs. When the enable bit clears, the block raises a ready interrupt request, provided software has enabled it. The block tracks whether the read-while-write section is blocked by an erase or write in progress. It also provides a separate short window in which a load-program strobe returns either the lock byte or the fuse byte.

Top module: `spm_ctrl`

## Requirements
- R1: After reset, `csr_rdata` reads 0x00. Bit 5 of `csr_rdata` always reads zero. The layout from bit 7 down is: irq-enable, section-busy, 0, re-enable, lock-set, page-write, page-erase, enable. A write with bit 0 clear updates only bit 7 and clears bits 4..0.
- R2: `irq` is high exactly when register bit 7 is one, `gie` is one and register bit 0 is zero.
- R3: A write with bit 0 set opens a window of WIN_CYC cycles. `spm_stb` is accepted in the 1st to WIN_CYC-th cycle after the write. If no strobe arrives in that window, bits 4..0 clear at the end of the window, and `fl_start`, `lock_wr` and `buf_clr` all stay low.
- R4: An accepted strobe on page erase (bit 1) pulses `fl_start` with `fl_cmd`=1. On page write (bit 2) it pulses `fl_start` with `fl_cmd`=2. Bit 0 then stays set until `fl_done`, after which bits 4..0 read zero.
- R5: An erase or write started with `tgt_rww`=1 sets `sect_busy` and register bit 6. An erase or write started with `tgt_rww`=0 leaves them unchanged.
- R6: A re-enable command (bits 4 and 0) accepted by a strobe pulses `buf_clr`, clears `sect_busy` and clears bits 4..0. A register write made while an erase or write is still running is ignored, except for bit 7.
- R7: An enable-only command (bit 0 with no command bits) accepted by a strobe pulses `fl_start` with `fl_cmd`=3 and clears `sect_busy`. A write with bit 4 set during that load pulses `buf_clr` in the same cycle and clears bit 0.
- R8: A lock-set command (bits 3 and 0) accepted by a strobe pulses `lock_wr` with `lock_wdata` equal to `r0_data`. Bits 3 and 0 then read zero.
- R9: A write with bits 3 and 0 set opens a read window of RD_WIN cycles. In that window, `lpm_stb` raises `lpm_hit`, and `lpm_data` is `fuse_byte` when `z_lsb`=1 and `lock_byte` when `z_lsb`=0. Outside the window, `lpm_hit` stays low.
- R10: When several command bits are set, a single strobe performs only one command, chosen in this order: lock-set, then re-enable, then erase, then write, then load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 8 | Control register write data |
| csr_rdata | output | 8 | Control register read value |
| gie | input | 1 | Global interrupt flag of the core |
| spm_stb | input | 1 | Store-program strobe |
| lpm_stb | input | 1 | Load-program strobe |
| z_lsb | input | 1 | Bit 0 of the address pointer |
| tgt_rww | input | 1 | Target page lies in the read-while-write section |
| r0_data | input | 8 | Low data byte from the core |
| lock_wr | output | 1 | Lock byte write pulse |
| lock_wdata | output | 8 | Lock byte value to write |
| lock_byte | input | 8 | Current lock byte |
| fuse_byte | input | 8 | Current fuse byte |
| lpm_hit | output | 1 | Load strobe falls inside the read window |
| lpm_data | output | 8 | Lock or fuse byte returned to the core |
| fl_start | output | 1 | Flash operation start pulse |
| fl_cmd | output | 2 | Flash command: 1 erase, 2 write, 3 buffer load |
| fl_done | input | 1 | Flash operation finished |
| buf_clr | output | 1 | Page buffer clear pulse |
| sect_busy | output | 1 | Read-while-write section is blocked |
| irq | output | 1 | Ready interrupt request |

## Verification
The bench builds the block with its defaults: a store window of WIN_CYC=4 and a read window of RD_WIN=3. These small windows let directed tests place strobes on the last accepted cycle and on the first rejected cycle of both windows. The flash done input is driven by hand, so a register write can land while an erase or a buffer load is still running. Register bit combinations exercise the command priority order.

// File: rtl/spm_ctrl.sv
module spm_ctrl #(
  parameter int WIN_CYC = 4,
  parameter int RD_WIN  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       csr_we,
  input  logic [7:0] csr_wdata,
  output logic [7:0] csr_rdata,
  input  logic       gie,
  input  logic       spm_stb,
  input  logic       lpm_stb,
  input  logic       z_lsb,
  input  logic       tgt_rww,
  input  logic [7:0] r0_data,
  output logic       lock_wr,
  output logic [7:0] lock_wdata,
  input  logic [7:0] lock_byte,
  input  logic [7:0] fuse_byte,
  output logic       lpm_hit,
  output logic [7:0] lpm_data,
  output logic       fl_start,
  output logic [1:0] fl_cmd,
  input  logic       fl_done,
  output logic       buf_clr,
  output logic       sect_busy,
  output logic       irq
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam int RW = $clog2(RD_WIN + 1);

  logic ie, busy_q, reen, lset, pw, pe, en, op, ld_op;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rcnt;

  wire armed   = en & ~op & (cnt != '0);
  wire go      = spm_stb & armed & ~csr_we;
  wire do_lock = go & lset;
  wire do_reen = go & ~lset & reen;
  wire do_er   = go & ~lset & ~reen & pe;
  wire do_wr   = go & ~lset & ~reen & ~pe & pw;
  wire do_ld   = go & ~lset & ~reen & ~pe & ~pw;
  wire wr_ok   = csr_we & ~op;
  wire abort   = csr_we & op & ld_op & csr_wdata[4];

  assign fl_start   = do_er | do_wr | do_ld;
  assign fl_cmd     = do_er ? 2'd1 : do_wr ? 2'd2 : do_ld ? 2'd3 : 2'd0;
  assign buf_clr    = do_reen | abort;
  assign lock_wr    = do_lock;
  assign lock_wdata = r0_data;
  assign lpm_hit    = lpm_stb & (rcnt != '0);
  assign lpm_data   = z_lsb ? fuse_byte : lock_byte;
  assign sect_busy  = busy_q;
  assign irq        = ie & gie & ~en;
  assign csr_rdata  = {ie, busy_q, 1'b0, reen, lset, pw, pe, en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; busy_q <= 1'b0; reen <= 1'b0; lset <= 1'b0;
      pw <= 1'b0; pe <= 1'b0; en <= 1'b0; op <= 1'b0; ld_op <= 1'b0;
      cnt <= '0; rcnt <= '0;
    end else begin
      if (rcnt != '0) rcnt <= rcnt - 1'b1;
      if (csr_we) ie <= csr_wdata[7];
      if (wr_ok) begin
        en   <= csr_wdata[0];
        pe   <= csr_wdata[0] & csr_wdata[1];
        pw   <= csr_wdata[0] & csr_wdata[2];
        lset <= csr_wdata[0] & csr_wdata[3];
        reen <= csr_wdata[0] & csr_wdata[4];
        cnt  <= csr_wdata[0] ? CW'(WIN_CYC) : '0;
        if (csr_wdata[0] & csr_wdata[3]) rcnt <= RW'(RD_WIN);
      end else if (op) begin
        if (abort | fl_done) begin
          op <= 1'b0; ld_op <= 1'b0; en <= 1'b0;
          {reen, lset, pw, pe} <= '0;
        end
      end else if (go) begin
        cnt <= '0;
        if (fl_start) begin
          op    <= 1'b1;
          ld_op <= do_ld;
        end else begin
          en <= 1'b0;
          {reen, lset, pw, pe} <= '0;
        end
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          en <= 1'b0;
          {reen, lset, pw, pe} <= '0;
        end
      end
      if (do_reen | do_ld) busy_q <= 1'b0;
      else if ((do_er | do_wr) & tgt_rww) busy_q <= 1'b1;
    end
  end
endmodule

module spm_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] csr_rdata,
  input logic       gie,
  input logic       tgt_rww,
  input logic       lock_wr,
  input logic       fl_start,
  input logic [1:0] fl_cmd,
  input logic       buf_clr,
  input logic       sect_busy,
  input logic       irq
);
  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[5] == 1'b0);
  assert_irq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && csr_rdata[7] && !csr_rdata[0]));
  assert_enable_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_start |=> csr_rdata[0]);
  assert_busy_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sect_busy) |-> $past(fl_start && tgt_rww && fl_cmd != 2'd3));
  assert_busy_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sect_busy) |-> $past(buf_clr || (fl_start && fl_cmd == 2'd3)));
  assert_lock_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |=> (!csr_rdata[3] && !csr_rdata[0]));
  assert_one_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lock_wr, fl_start}));
endmodule

bind spm_ctrl spm_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .csr_rdata(csr_rdata), .gie(gie), .tgt_rww(tgt_rww),
  .lock_wr(lock_wr), .fl_start(fl_start), .fl_cmd(fl_cmd), .buf_clr(buf_clr),
  .sect_busy(sect_busy), .irq(irq)
);

// File: tb/spm_ctrl_test.sv
`timescale 1ns/100ps
module spm_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csr_we = 0, gie = 0, spm_stb = 0, lpm_stb = 0, z_lsb = 0, tgt_rww = 0, fl_done = 0;
  logic [7:0] csr_wdata = 0, r0_data = 0, lock_byte = 8'h3C, fuse_byte = 8'hD1;
  logic [7:0] csr_rdata, lock_wdata, lpm_data;
  logic lock_wr, lpm_hit, fl_start, buf_clr, sect_busy, irq;
  logic [1:0] fl_cmd;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  spm_ctrl uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic wr(input logic [7:0] v);
    csr_we = 1; csr_wdata = v; tick(); csr_we = 0;
  endtask

  // Strobe in the k-th cycle after a register write; check comb outputs, then pass the edge.
  task automatic strobe_at(input int k);
    for (int i = 1; i < k; i++) tick();
    spm_stb = 1; #1;
  endtask

  task automatic done_pulse();
    fl_done = 1; tick(); fl_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset rdata", csr_rdata, 8'h00);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset busy", sect_busy, 0);
    wr(8'hBE);
    chk("R1 write without enable", csr_rdata, 8'h80);
    wr(8'h00);
  endtask

  task automatic t_irq();
    gie = 1; wr(8'h80);
    chk("R2 irq on", irq, 1);
    gie = 0; #1;
    chk("R2 irq gated by gie", irq, 0);
    gie = 1; #1;
  endtask

  task automatic t_erase();
    tgt_rww = 1; wr(8'h83);
    strobe_at(1);
    chk("R4 erase start", fl_start, 1);
    chk("R4 erase cmd", fl_cmd, 1);
    tick(); spm_stb = 0;
    chk("R5 busy set", sect_busy, 1);
    chk("R4 enable held", csr_rdata, 8'hC3);
    chk("R2 irq low while running", irq, 0);
    wr(8'h91);
    chk("R6 write ignored while running", csr_rdata, 8'hC3);
    done_pulse();
    chk("R4 cleared on done", csr_rdata, 8'hC0);
    chk("R2 irq after done", irq, 1);
    wr(8'h91);
    strobe_at(4);
    chk("R6 reenable buf_clr", buf_clr, 1);
    chk("R3 last window cycle no start", fl_start, 0);
    tick(); spm_stb = 0;
    chk("R6 busy cleared", sect_busy, 0);
    chk("R6 bits cleared", csr_rdata, 8'h80);
    tgt_rww = 0;
  endtask

  task automatic t_timeout();
    wr(8'h85);
    for (int i = 0; i < 3; i++) tick();
    chk("R3 still armed", csr_rdata, 8'h85);
    tick();
    chk("R3 expired clear", csr_rdata, 8'h80);
    spm_stb = 1; #1;
    chk("R3 late strobe no start", fl_start, 0);
    chk("R3 late strobe no buf_clr", buf_clr, 0);
    tick(); spm_stb = 0;
    tgt_rww = 1; wr(8'h83); tgt_rww = 0;
    for (int i = 0; i < 4; i++) tick();
    chk("R3 erase expiry leaves busy", sect_busy, 0);
  endtask

  task automatic t_lock();
    r0_data = 8'hA5; wr(8'h89);
    tick();
    lpm_stb = 1; z_lsb = 0; #1;
    chk("R9 read hit", lpm_hit, 1);
    chk("R9 lock byte", lpm_data, 8'h3C);
    z_lsb = 1; #1;
    chk("R9 fuse byte", lpm_data, 8'hD1);
    tick();
    chk("R9 third cycle hit", lpm_hit, 1);
    tick();
    chk("R9 window closed", lpm_hit, 0);
    lpm_stb = 0;
    spm_stb = 1; #1;
    chk("R8 lock write", lock_wr, 1);
    chk("R8 lock data", lock_wdata, 8'hA5);
    tick(); spm_stb = 0;
    chk("R8 bits cleared", csr_rdata, 8'h80);
    wr(8'h89);
    for (int i = 0; i < 4; i++) tick();
    chk("R3 lock expiry", csr_rdata, 8'h80);
  endtask

  task automatic t_priority();
    wr(8'h8F); strobe_at(1);
    chk("R10 lock wins", lock_wr, 1);
    chk("R10 no flash start", fl_start, 0);
    tick(); spm_stb = 0;
    wr(8'h97); strobe_at(2);
    chk("R10 reenable wins", buf_clr, 1);
    chk("R10 no start vs reenable", fl_start, 0);
    tick(); spm_stb = 0;
    wr(8'h87); strobe_at(1);
    chk("R10 erase over write", fl_cmd, 1);
    tick(); spm_stb = 0; done_pulse();
    wr(8'h85); strobe_at(3);
    chk("R4 write cmd", fl_cmd, 2);
    tick(); spm_stb = 0;
    chk("R5 rww=0 keeps busy low", sect_busy, 0);
    done_pulse();
  endtask

  task automatic t_load();
    tgt_rww = 1; wr(8'h83); strobe_at(1); tick(); spm_stb = 0; tgt_rww = 0; done_pulse();
    chk("R5 busy before load", sect_busy, 1);
    wr(8'h81); strobe_at(1);
    chk("R7 load start", fl_start, 1);
    chk("R7 load cmd", fl_cmd, 3);
    tick(); spm_stb = 0;
    chk("R7 load clears busy", sect_busy, 0);
    chk("R7 enable held", csr_rdata[0], 1);
    csr_we = 1; csr_wdata = 8'h91; #1;
    chk("R7 abort buf_clr", buf_clr, 1);
    tick(); csr_we = 0;
    chk("R7 abort clears enable", csr_rdata, 8'h80);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset rdata in reset", csr_rdata, 8'h00);
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_irq();
    t_erase();
    t_timeout();
    t_lock();
    t_priority();
    t_load();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule